// File: doc/BRIEF.md
# Instruction Opcode Decoder and Engine Dispatcher

This block sits between an instruction queue and the execution engines of a neural accelerator. Each 64-bit instruction word arrives with a valid/ready handshake. The block reads the 4-bit opcode in the top nibble, cuts the remaining bits into the fields of that opcode, and offers a structured command on one of three engine ports. The ports are compute (vector and matrix multiply), copy (data movement) and complex vector operation. Each port has its own valid/ready pair. The queue entry is consumed only in the cycle in which the chosen port takes the command. Instructions therefore leave in strict order, and a stalled port holds back everything behind it.

Shape-descriptor writes are not forwarded. The block keeps two 64-entry shape tables, one for feature maps and one for weights. A shape-write instruction updates one entry of one table in a single cycle. Compute and copy commands carry the shape triples read from these tables at the pointer fields of the instruction. Instructions that cannot be decoded are consumed and discarded, and they raise a sticky error flag.

Top module: `instr_dispatch`

## Requirements
- R1: Opcode 0x0 (vector) and 0x1 (matrix) go to the compute port, with `cmp_matrix` equal to opcode bit 0. The fields are destination [59:43], source [42:26], flags [25:20], lanes [7:3]. Flags bit 5 asks for the output maximum, bit 4 for accumulation, bit 3 for weight scaling. Bits [2:0] are ignored.
- R2: A compute command carries `cmp_size_dims` = feature-map table entry at index [19:14] and `cmp_shape_dims` = weight table entry at index [13:8]. Each entry is packed as {first value [47:32], second [31:16], third [15:0]}.
- R3: Opcode 0x4 goes to the vector-operation port with function [59:56], source [55:39], destination [38:22], element count [21:6], flags [5:1] and async [0].
- R4: Opcode 0x2 with bits [23:7] all zero goes to the copy port. The fields are from-device [59], to-device [58], destination [57:41], source [40:24] and async [0]. `cpy_dims` is the feature-map table entry at index [6:1].
- R5: Opcode 0x3 with target [59:58] equal to 0 (feature-map table) or 1 (weight table) is accepted at once, raises no port valid, and writes {[51:36],[35:20],[19:4]} into entry [57:52] of that table. The write is visible to the next instruction.
- R6: An opcode of 0x5 to 0xF, a shape write with target 2 or 3, or a copy with nonzero bits [23:7] is accepted at once. It raises no port valid and changes no table. It sets `err_flag`, which stays set until reset.
- R7: At most one port valid is high, and only while `in_valid` is high. When the selected port is not ready, `in_ready` is low, so the instruction is neither lost nor passed over.
- R8: Reset clears both tables to zero and clears `err_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word present |
| in_word | input | 64 | Instruction word |
| in_ready | output | 1 | Instruction consumed this cycle |
| cmp_valid | output | 1 | Compute command offered |
| cmp_ready | input | 1 | Compute engine accepts |
| cmp_matrix | output | 1 | 1 = matrix engine, 0 = vector engine |
| cmp_dst | output | 17 | Compute destination |
| cmp_src | output | 17 | Compute source |
| cmp_flags | output | 6 | Compute flags |
| cmp_lanes | output | 5 | Active lane count |
| cmp_size_dims | output | 48 | Feature-map table entry at the size pointer |
| cmp_shape_dims | output | 48 | Weight table entry at the shape pointer |
| cpy_valid | output | 1 | Copy command offered |
| cpy_ready | input | 1 | Copy engine accepts |
| cpy_from | output | 1 | Source device bit |
| cpy_to | output | 1 | Target device bit |
| cpy_dst | output | 17 | Copy destination |
| cpy_src | output | 17 | Copy source |
| cpy_async | output | 1 | Fire-and-forget flag |
| cpy_dims | output | 48 | Feature-map table entry at the copy shape pointer |
| cvo_valid | output | 1 | Vector-operation command offered |
| cvo_ready | input | 1 | Vector-operation engine accepts |
| cvo_func | output | 4 | Function code |
| cvo_src | output | 17 | Source address |
| cvo_dst | output | 17 | Destination address |
| cvo_count | output | 16 | Element count |
| cvo_flags | output | 5 | Operation flags |
| cvo_async | output | 1 | Fire-and-forget flag |
| err_flag | output | 1 | Sticky undecodable-instruction flag |

## Verification
The assertions assume that reset is applied before the first instruction. They do not assume that the queue holds its word steady during a stall; they check only that a refused port keeps `in_ready` low. The engine ready inputs may toggle freely from cycle to cycle, and the stimulus randomizes them independently of the offered command. During a stall the bench still holds the stalled word, as a real queue would. Shape-table indices are drawn from a small range, so that writes and later reads of the same entry meet often.

// File: rtl/disp_pkg.sv
package disp_pkg;
  localparam int ADDR_W  = 17;
  localparam int PTR_W   = 6;
  localparam int VAL_W   = 16;
  localparam int DIMS_W  = 3 * VAL_W;

  typedef enum logic [2:0] {K_CMP, K_CPY, K_SET, K_CVO, K_BAD} kind_e;

  typedef struct packed {
    logic              matrix;
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src;
    logic [5:0]        flags;
    logic [PTR_W-1:0]  szp;
    logic [PTR_W-1:0]  shp;
    logic [4:0]        lanes;
  } cmp_t;

  typedef struct packed {
    logic              from_dev;
    logic              to_dev;
    logic [ADDR_W-1:0] dst;
    logic [ADDR_W-1:0] src;
    logic [PTR_W-1:0]  shp;
    logic              async;
  } cpy_t;

  typedef struct packed {
    logic [3:0]        func;
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [15:0]       count;
    logic [4:0]        flags;
    logic              async;
  } cvo_t;

  typedef struct packed {
    logic [1:0]        target;
    logic [PTR_W-1:0]  idx;
    logic [DIMS_W-1:0] dims;
  } set_t;

  function automatic cmp_t get_cmp(input logic [63:0] w);
    cmp_t c;
    c.matrix = w[60];
    c.dst    = w[59:43];
    c.src    = w[42:26];
    c.flags  = w[25:20];
    c.szp    = w[19:14];
    c.shp    = w[13:8];
    c.lanes  = w[7:3];
    return c;
  endfunction

  function automatic cpy_t get_cpy(input logic [63:0] w);
    cpy_t c;
    c.from_dev = w[59];
    c.to_dev   = w[58];
    c.dst      = w[57:41];
    c.src      = w[40:24];
    c.shp      = w[6:1];
    c.async    = w[0];
    return c;
  endfunction

  function automatic cvo_t get_cvo(input logic [63:0] w);
    cvo_t c;
    c.func  = w[59:56];
    c.src   = w[55:39];
    c.dst   = w[38:22];
    c.count = w[21:6];
    c.flags = w[5:1];
    c.async = w[0];
    return c;
  endfunction

  function automatic set_t get_set(input logic [63:0] w);
    set_t s;
    s.target = w[59:58];
    s.idx    = w[57:52];
    s.dims   = w[51:4];
    return s;
  endfunction
endpackage

// File: rtl/op_decoder.sv
module op_decoder
  import disp_pkg::*;
(
  input  logic [63:0] word,
  output kind_e       kind
);
  logic [3:0] opc;
  logic       aux_clear;
  logic       target_ok;

  assign opc       = word[63:60];
  assign aux_clear = (word[23:7] == '0);
  assign target_ok = !word[59];

  always_comb begin
    case (opc)
      4'h0, 4'h1: kind = K_CMP;
      4'h2:       kind = aux_clear ? K_CPY : K_BAD;
      4'h3:       kind = target_ok ? K_SET : K_BAD;
      4'h4:       kind = K_CVO;
      default:    kind = K_BAD;
    endcase
  end
endmodule

// File: rtl/shape_store.sv
module shape_store #(
  parameter int IDX_W = 6,
  parameter int VAL_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] widx,
  input  logic [VAL_W-1:0] wdata,
  input  logic [IDX_W-1:0] ridx,
  output logic [VAL_W-1:0] rdata
);
  localparam int DEPTH = 1 << IDX_W;

  logic [VAL_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata = mem[ridx];
endmodule

// File: rtl/instr_dispatch.sv
module instr_dispatch
  import disp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [63:0]       in_word,
  output logic              in_ready,
  output logic              cmp_valid,
  input  logic              cmp_ready,
  output logic              cmp_matrix,
  output logic [16:0]       cmp_dst,
  output logic [16:0]       cmp_src,
  output logic [5:0]        cmp_flags,
  output logic [4:0]        cmp_lanes,
  output logic [47:0]       cmp_size_dims,
  output logic [47:0]       cmp_shape_dims,
  output logic              cpy_valid,
  input  logic              cpy_ready,
  output logic              cpy_from,
  output logic              cpy_to,
  output logic [16:0]       cpy_dst,
  output logic [16:0]       cpy_src,
  output logic              cpy_async,
  output logic [47:0]       cpy_dims,
  output logic              cvo_valid,
  input  logic              cvo_ready,
  output logic [3:0]        cvo_func,
  output logic [16:0]       cvo_src,
  output logic [16:0]       cvo_dst,
  output logic [15:0]       cvo_count,
  output logic [4:0]        cvo_flags,
  output logic              cvo_async,
  output logic              err_flag
);
  localparam int NTAB = 2;  // 0 = feature-map table, 1 = weight table

  kind_e kind;
  cmp_t  c_cmp;
  cpy_t  c_cpy;
  cvo_t  c_cvo;
  set_t  c_set;

  // named events for the checker
  logic accept_evt;
  logic set_evt;
  logic drop_evt;

  logic              tab_we   [NTAB];
  logic [PTR_W-1:0]  tab_ridx [NTAB];
  logic [DIMS_W-1:0] tab_rd   [NTAB];

  op_decoder u_dec (.word(in_word), .kind(kind));

  assign c_cmp = get_cmp(in_word);
  assign c_cpy = get_cpy(in_word);
  assign c_cvo = get_cvo(in_word);
  assign c_set = get_set(in_word);

  // routing and backpressure
  always_comb begin
    cmp_valid = in_valid && (kind == K_CMP);
    cpy_valid = in_valid && (kind == K_CPY);
    cvo_valid = in_valid && (kind == K_CVO);
    case (kind)
      K_CMP:   in_ready = cmp_ready;
      K_CPY:   in_ready = cpy_ready;
      K_CVO:   in_ready = cvo_ready;
      default: in_ready = 1'b1;
    endcase
  end

  assign accept_evt = in_valid && in_ready;
  assign set_evt    = accept_evt && (kind == K_SET);
  assign drop_evt   = accept_evt && (kind == K_BAD);

  // shape tables
  assign tab_ridx[0] = (kind == K_CPY) ? c_cpy.shp : c_cmp.szp;
  assign tab_ridx[1] = c_cmp.shp;

  for (genvar t = 0; t < NTAB; t++) begin : g_tab
    assign tab_we[t] = set_evt && (c_set.target[0] == t[0]);
    shape_store #(.IDX_W(PTR_W), .VAL_W(DIMS_W)) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (tab_we[t]),
      .widx  (c_set.idx),
      .wdata (c_set.dims),
      .ridx  (tab_ridx[t]),
      .rdata (tab_rd[t])
    );
  end

  // sticky error
  always_ff @(posedge clk) begin
    if (!rst_n)        err_flag <= 1'b0;
    else if (drop_evt) err_flag <= 1'b1;
  end

  // port payloads
  assign cmp_matrix     = c_cmp.matrix;
  assign cmp_dst        = c_cmp.dst;
  assign cmp_src        = c_cmp.src;
  assign cmp_flags      = c_cmp.flags;
  assign cmp_lanes      = c_cmp.lanes;
  assign cmp_size_dims  = tab_rd[0];
  assign cmp_shape_dims = tab_rd[1];

  assign cpy_from  = c_cpy.from_dev;
  assign cpy_to    = c_cpy.to_dev;
  assign cpy_dst   = c_cpy.dst;
  assign cpy_src   = c_cpy.src;
  assign cpy_async = c_cpy.async;
  assign cpy_dims  = tab_rd[0];

  assign cvo_func  = c_cvo.func;
  assign cvo_src   = c_cvo.src;
  assign cvo_dst   = c_cvo.dst;
  assign cvo_count = c_cvo.count;
  assign cvo_flags = c_cvo.flags;
  assign cvo_async = c_cvo.async;
endmodule

// File: rtl/disp_checker.sv
module disp_checker (
  input logic clk,
  input logic rst_n,
  input logic in_valid,
  input logic in_ready,
  input logic cmp_valid,
  input logic cmp_ready,
  input logic cpy_valid,
  input logic cpy_ready,
  input logic cvo_valid,
  input logic cvo_ready,
  input logic err_flag,
  input logic set_evt,
  input logic drop_evt
);
  // R7
  one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmp_valid, cpy_valid, cvo_valid}));

  // R7
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_valid || cpy_valid || cvo_valid) |-> in_valid);

  // R7
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmp_valid && !cmp_ready) || (cpy_valid && !cpy_ready) ||
     (cvo_valid && !cvo_ready)) |-> !in_ready);

  // R5
  set_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |-> (in_ready && !cmp_valid && !cpy_valid && !cvo_valid));

  // R6
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |-> !(cmp_valid || cpy_valid || cvo_valid));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);

  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_flag && !drop_evt) |=> !err_flag);
endmodule

bind instr_dispatch disp_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .cmp_valid (cmp_valid),
  .cmp_ready (cmp_ready),
  .cpy_valid (cpy_valid),
  .cpy_ready (cpy_ready),
  .cvo_valid (cvo_valid),
  .cvo_ready (cvo_ready),
  .err_flag  (err_flag),
  .set_evt   (set_evt),
  .drop_evt  (drop_evt)
);

// File: tb/sim_instr_dispatch.sv
module sim_instr_dispatch;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [63:0] in_word = '0;
  logic in_ready;
  logic cmp_valid, cmp_ready = 1'b0, cmp_matrix;
  logic [16:0] cmp_dst, cmp_src;
  logic [5:0] cmp_flags;
  logic [4:0] cmp_lanes;
  logic [47:0] cmp_size_dims, cmp_shape_dims;
  logic cpy_valid, cpy_ready = 1'b0, cpy_from, cpy_to, cpy_async;
  logic [16:0] cpy_dst, cpy_src;
  logic [47:0] cpy_dims;
  logic cvo_valid, cvo_ready = 1'b0, cvo_async;
  logic [3:0] cvo_func;
  logic [16:0] cvo_src, cvo_dst;
  logic [15:0] cvo_count;
  logic [4:0] cvo_flags;
  logic err_flag;

  int checks = 0;
  int failures = 0;
  logic [47:0] m_fm [64];
  logic [47:0] m_wt [64];
  logic m_err = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  instr_dispatch u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // 0 compute, 1 copy, 2 shape write, 3 vector op, 4 dropped
  function automatic int bkind(input logic [63:0] w);
    int op = int'(w >> 60);
    if (op <= 1) return 0;
    if (op == 2) return (((w >> 7) & 64'h1FFFF) == 0) ? 1 : 4;
    if (op == 3) return (((w >> 58) & 64'h3) < 2) ? 2 : 4;
    if (op == 4) return 3;
    return 4;
  endfunction

  function automatic logic [63:0] fld(input logic [63:0] w, input int lo, input int n);
    return (w >> lo) & ((64'd1 << n) - 1);
  endfunction

  function automatic logic [63:0] mk_cmp(input int op, input int dst, input int src,
      input int fl, input int szp, input int shp, input int ln, input int rsv);
    return (64'(op) << 60) | (64'(dst & 'h1FFFF) << 43) | (64'(src & 'h1FFFF) << 26) |
           (64'(fl & 'h3F) << 20) | (64'(szp & 'h3F) << 14) | (64'(shp & 'h3F) << 8) |
           (64'(ln & 'h1F) << 3) | 64'(rsv & 7);
  endfunction

  function automatic logic [63:0] mk_set(input int tgt, input int idx,
      input int a, input int b, input int c);
    return (64'h3 << 60) | (64'(tgt & 3) << 58) | (64'(idx & 'h3F) << 52) |
           (64'(a & 'hFFFF) << 36) | (64'(b & 'hFFFF) << 20) | (64'(c & 'hFFFF) << 4);
  endfunction

  function automatic logic [63:0] mk_cpy(input int fr, input int to, input int dst,
      input int src, input int aux, input int shp, input int as);
    return (64'h2 << 60) | (64'(fr & 1) << 59) | (64'(to & 1) << 58) |
           (64'(dst & 'h1FFFF) << 41) | (64'(src & 'h1FFFF) << 24) |
           (64'(aux & 'h1FFFF) << 7) | (64'(shp & 'h3F) << 1) | 64'(as & 1);
  endfunction

  function automatic logic [63:0] mk_cvo(input int fn, input int src, input int dst,
      input int cnt, input int fl, input int as);
    return (64'h4 << 60) | (64'(fn & 'hF) << 56) | (64'(src & 'h1FFFF) << 39) |
           (64'(dst & 'h1FFFF) << 22) | (64'(cnt & 'hFFFF) << 6) |
           (64'(fl & 'h1F) << 1) | 64'(as & 1);
  endfunction

  task automatic step(input logic v, input logic [63:0] w, input logic rc,
      input logic rp, input logic rv, output logic acc);
    int k;
    logic er;
    @(negedge clk);
    in_valid = v; in_word = w; cmp_ready = rc; cpy_ready = rp; cvo_ready = rv;
    #1;
    k = bkind(w);
    er = (k == 0) ? rc : (k == 1) ? rp : (k == 3) ? rv : 1'b1;
    chk("R7 in_ready", 64'(in_ready), 64'(er));
    chk("R7 port valids", 64'({cmp_valid, cpy_valid, cvo_valid}),
        v ? 64'({k == 0, k == 1, k == 3}) : 64'd0);
    chk("R6 err_flag", 64'(err_flag), 64'(m_err));
    if (v && k == 0) begin
      chk("R1 compute fields",
          64'({cmp_matrix, cmp_dst, cmp_src, cmp_flags, cmp_lanes}),
          (fld(w, 60, 1) << 45) | (fld(w, 43, 17) << 28) | (fld(w, 26, 17) << 11) |
          (fld(w, 20, 6) << 5) | fld(w, 3, 5));
      chk("R2 size dims", 64'(cmp_size_dims), 64'(m_fm[fld(w, 14, 6)]));
      chk("R2 shape dims", 64'(cmp_shape_dims), 64'(m_wt[fld(w, 8, 6)]));
    end
    if (v && k == 1) begin
      chk("R4 copy fields", 64'({cpy_from, cpy_to, cpy_dst, cpy_src, cpy_async}),
          (fld(w, 59, 1) << 36) | (fld(w, 58, 1) << 35) | (fld(w, 41, 17) << 18) |
          (fld(w, 24, 17) << 1) | fld(w, 0, 1));
      chk("R4 copy dims", 64'(cpy_dims), 64'(m_fm[fld(w, 1, 6)]));
    end
    if (v && k == 3) begin
      chk("R3 vector-op fields",
          64'({cvo_func, cvo_src, cvo_dst, cvo_count, cvo_flags, cvo_async}),
          (fld(w, 56, 4) << 56) | (fld(w, 39, 17) << 39) | (fld(w, 22, 17) << 22) |
          (fld(w, 6, 16) << 6) | (fld(w, 1, 5) << 1) | fld(w, 0, 1));
    end
    acc = v && er;
    if (acc && k == 2) begin
      if (fld(w, 58, 2) == 0) m_fm[fld(w, 52, 6)] = 48'(fld(w, 4, 48));
      else                    m_wt[fld(w, 52, 6)] = 48'(fld(w, 4, 48));
    end
    if (acc && k == 4) m_err = 1'b1;
    @(posedge clk);
  endtask

  function automatic logic [63:0] rnd_word();
    int sel = int'($urandom % 16);
    case (sel)
      0, 1, 2, 3, 15:
        return mk_cmp(sel & 1, $urandom, $urandom, $urandom, $urandom % 8,
                      $urandom % 8, $urandom, $urandom);
      4, 5, 6:
        return mk_cpy($urandom, $urandom, $urandom, $urandom,
                      ($urandom % 8 == 0) ? 1 + ($urandom % 'h1FFFE) : 0,
                      $urandom % 8, $urandom);
      7, 8, 9, 10:
        return mk_set(($urandom % 6 == 0) ? 2 + ($urandom % 2) : ($urandom % 2),
                      $urandom % 8, $urandom, $urandom, $urandom);
      11, 12, 13:
        return mk_cvo($urandom, $urandom, $urandom, $urandom, $urandom, $urandom);
      default:
        return (64'(5 + ($urandom % 11)) << 60) | {$urandom, $urandom} >> 4;
    endcase
  endfunction

  initial begin
    #(8 * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic a;
    logic [63:0] w;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 64; i++) begin m_fm[i] = '0; m_wt[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R8: reset state, tables read zero
    step(1'b0, 64'd0, 1'b1, 1'b1, 1'b1, a);
    step(1'b1, mk_cmp(0, 1, 2, 'h38, 63, 63, 4, 0), 1'b1, 1'b1, 1'b1, a);
    chk("R8 compute accepted after reset", 64'(a), 64'd1);

    // R5: shape writes visible to the very next instruction
    step(1'b1, mk_set(0, 5, 'h1111, 'h2222, 'h3333), 1'b0, 1'b0, 1'b0, a);
    chk("R5 shape write accepted with ports stalled", 64'(a), 64'd1);
    step(1'b1, mk_set(1, 63, 'hAAAA, 'hBBBB, 'hCCCC), 1'b0, 1'b0, 1'b0, a);
    step(1'b1, mk_cmp(1, 7, 8, 'h10, 5, 63, 31, 7), 1'b1, 1'b0, 1'b0, a);
    step(1'b1, mk_cpy(1, 0, 3, 4, 0, 5, 1), 1'b0, 1'b1, 1'b0, a);

    // R7: stalled compute holds the word, then goes
    step(1'b1, mk_cmp(0, 9, 9, 'h20, 5, 63, 2, 0), 1'b0, 1'b1, 1'b1, a);
    chk("R7 stalled compute not consumed", 64'(a), 64'd0);
    step(1'b1, mk_cmp(0, 9, 9, 'h20, 5, 63, 2, 0), 1'b1, 1'b0, 1'b0, a);
    chk("R7 compute consumed once ready", 64'(a), 64'd1);

    // R6: bad target leaves table untouched and sets error
    step(1'b1, mk_set(2, 5, 'hDEAD, 'hBEEF, 'hF00D), 1'b1, 1'b1, 1'b1, a);
    step(1'b1, mk_cmp(0, 0, 0, 0, 5, 5, 1, 0), 1'b1, 1'b1, 1'b1, a);
    chk("R6 error after bad shape write", 64'(err_flag), 64'd1);

    // R6: copy with nonzero auxiliary field, top opcode
    step(1'b1, mk_cpy(0, 1, 1, 1, 'h10000, 5, 0), 1'b1, 1'b1, 1'b1, a);
    step(1'b1, 64'hF000_0000_0000_0000, 1'b0, 1'b0, 1'b0, a);
    chk("R6 top opcode consumed", 64'(a), 64'd1);

    // random stream with held words during stalls
    w = rnd_word();
    for (int n = 0; n < 4000; n++) begin
      step(($urandom % 8) != 0, w, ($urandom % 10) < 7, ($urandom % 10) < 7,
           ($urandom % 10) < 7, a);
      if (a) w = rnd_word();
    end

    // R8: reset clears tables and error
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    for (int i = 0; i < 64; i++) begin m_fm[i] = '0; m_wt[i] = '0; end
    m_err = 1'b0;
    step(1'b1, mk_cmp(0, 0, 0, 0, 5, 63, 0, 0), 1'b1, 1'b1, 1'b1, a);
    chk("R8 error cleared by reset", 64'(err_flag), 64'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule